// File: doc/BRIEF.md
# Nibble-Format Multicycle Byte Processor

This block is a small processor core. It has sixteen 8-bit working registers, a program counter and a 16-bit instruction register. It works on a 256-byte memory that sits inside the block. Every instruction is two bytes long and is read one byte at a time. The core then decodes it and carries it out. It knows four operations: a memory-to-register load, a register-to-memory store, an 8-bit two's-complement add of two registers and a halt. Every other opcode passes through as an empty instruction.

The controller is a six-state machine:

- `ST_FETCH_HI` puts the program counter on the bus.
- `ST_FETCH_LO` latches the first instruction byte and puts the counter plus one on the bus.
- `ST_DECODE` latches the second byte and advances the counter by two.
- `ST_EXEC` performs the operation.
- `ST_WRITEBACK` is entered only by a load. It writes the returned memory byte into the register file.
- `ST_HALT` is a terminal state.

The transitions are as follows:

- Fetch-high goes to fetch-low.
- Fetch-low goes to decode.
- Decode goes to execute.
- Execute goes to write-back for opcode 1, to halt for opcode C, and back to fetch-high for every other opcode.
- Write-back returns to fetch-high.
- Halt stays in halt until reset.

Memory reads are synchronous: the data for an address presented in one cycle arrives in the next. A store therefore takes four cycles, an add four, and a load five. While reset is held, the environment fills memory through a separate byte-wide load port. Results are observed on the memory bus outputs, on a halted flag and on a register-file debug read port.

Top module: `simple_cpu`

## Requirements
- R1: While reset is low, and after it is released, every register reads 00 and halted is low. In the first cycle after release the bus address is A0.
- R2: An instruction is read high byte first: the byte at the program counter, then the byte at the counter plus one. In the first byte, the upper nibble is the opcode and the lower nibble is R. The second byte is either an address XY, or S in its upper nibble and T in its lower.
- R3: Opcode 1 (1RXY) copies the memory byte at address XY into register R.
- R4: Opcode 3 (3RXY) raises mem_we for exactly one cycle, with mem_addr = XY and mem_wdata = register R.
- R5: Opcode 5 (5RST) writes (S + T) mod 256 into register R. A carry out is discarded.
- R6: When the destination of an add is also one of its sources, the sum uses the register values from before the instruction.
- R7: Opcode C (C000) raises halted, which stays high until reset. After that there are no memory writes, mem_addr holds still and the registers keep their values.
- R8: Any opcode other than 1, 3, 5 and C changes no register and no memory cell. Execution continues with the next byte pair.
- R9: The program counter advances by two per instruction and wraps modulo 256, so an instruction at FE is followed by one at 00.
- R10: A load-port write (load_en high) stores load_data at load_addr on the next clock edge. It has priority over a store in the same cycle.
- R11: A load from an address that an earlier store wrote returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load-port write strobe |
| load_addr | input | 8 | Load-port cell address |
| load_data | input | 8 | Load-port byte |
| dbg_sel | input | 4 | Register index for the debug read |
| dbg_data | output | 8 | Current value of the selected register |
| halted | output | 1 | High once a halt has executed |
| mem_addr | output | 8 | Address driven by the core on the memory bus |
| mem_wdata | output | 8 | Store data on the memory bus |
| mem_we | output | 1 | Store strobe on the memory bus |
| mem_rdata | output | 8 | Registered read data returned by memory |

## Verification
The add instruction reads its two source registers and writes its destination on the same clock edge. The program therefore includes an add whose destination equals a source, 5556, and checks that R5 ends up holding the old R5 plus R6 rather than a doubled or stale value. In a second collision, a store and a later load to the same cell are spaced only one instruction apart. The value the load returns must equal the data that the store monitor saw on the bus.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_DECODE,
        ST_EXEC,
        ST_WRITEBACK,
        ST_HALT
    } cpu_state_e;

    localparam logic [3:0] OPC_LOAD  = 4'h1;
    localparam logic [3:0] OPC_STORE = 4'h3;
    localparam logic [3:0] OPC_ADD   = 4'h5;
    localparam logic [3:0] OPC_HALT  = 4'hC;

endpackage

// File: rtl/cpu_adder.sv
module cpu_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [DW-1:0] sum
);
    // carry out is deliberately dropped: result wraps modulo 2**DW
    logic [DW:0] full;
    assign full = {1'b0, op_a} + {1'b0, op_b};
    assign sum  = full[DW-1:0];
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DW  = 8,
    parameter int RAW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] ra_a,
    input  logic [RAW-1:0] ra_b,
    input  logic [RAW-1:0] ra_dbg,
    output logic [DW-1:0]  rd_a,
    output logic [DW-1:0]  rd_b,
    output logic [DW-1:0]  rd_dbg,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [DW-1:0]  wd
);
    localparam int NREG = 1 << RAW;

    logic [DW-1:0] regs [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[gi] <= '0;
            end else if (we && (wa == RAW'(gi))) begin
                regs[gi] <= wd;
            end
        end
    end

    assign rd_a   = regs[ra_a];
    assign rd_b   = regs[ra_b];
    assign rd_dbg = regs[ra_dbg];
endmodule

// File: rtl/cpu_memory.sv
module cpu_memory #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // load port wins over a core store in the same cycle
    always_ff @(posedge clk) begin
        if (ld_en) begin
            cells[ld_addr] <= ld_data;
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    // synchronous read, old data on a same-cycle write
    always_ff @(posedge clk) begin
        rdata <= cells[addr];
    end
endmodule

// File: rtl/cpu_control.sv
module cpu_control
    import cpu_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter int            RAW      = 4,
    parameter logic [AW-1:0] RESET_PC = 8'hA0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           mem_we,
    output logic [RAW-1:0] rf_ra_a,
    output logic [RAW-1:0] rf_ra_b,
    input  logic [DW-1:0]  rf_rd_a,
    input  logic [DW-1:0]  rf_rd_b,
    output logic           rf_we,
    output logic [RAW-1:0] rf_wa,
    output logic [DW-1:0]  rf_wd,
    output logic           halted,
    output cpu_state_e     state_o
);
    localparam int          IW      = 2 * DW;
    localparam int          OPW     = 4;
    localparam logic [AW-1:0] PC_STEP = AW'(2);

    cpu_state_e    state, state_nxt;
    logic [AW-1:0] pc;
    logic [IW-1:0] ir;
    logic [DW-1:0] sum;

    logic [OPW-1:0] f_op;
    logic [RAW-1:0] f_r, f_s, f_t;
    logic [AW-1:0]  f_xy;

    assign f_op = ir[IW-1 -: OPW];
    assign f_r  = ir[IW-OPW-1 -: RAW];
    assign f_s  = ir[DW-1 -: RAW];
    assign f_t  = ir[RAW-1:0];
    assign f_xy = ir[AW-1:0];

    cpu_adder #(.DW(DW)) u_add (
        .op_a (rf_rd_a),
        .op_b (rf_rd_b),
        .sum  (sum)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH_HI;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FETCH_HI:  state_nxt = ST_FETCH_LO;
            ST_FETCH_LO:  state_nxt = ST_DECODE;
            ST_DECODE:    state_nxt = ST_EXEC;
            ST_EXEC: begin
                if (f_op == OPC_LOAD)      state_nxt = ST_WRITEBACK;
                else if (f_op == OPC_HALT) state_nxt = ST_HALT;
                else                       state_nxt = ST_FETCH_HI;
            end
            ST_WRITEBACK: state_nxt = ST_FETCH_HI;
            ST_HALT:      state_nxt = ST_HALT;
            default:      state_nxt = ST_FETCH_HI;
        endcase
    end

    // program counter and instruction register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= RESET_PC;
            ir <= '0;
        end else begin
            if (state == ST_FETCH_LO) ir[IW-1:DW] <= mem_rdata;
            if (state == ST_DECODE) begin
                ir[DW-1:0] <= mem_rdata;
                pc         <= pc + PC_STEP;
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = rf_rd_a;
        rf_ra_a   = (f_op == OPC_STORE) ? f_r : f_s;
        rf_ra_b   = f_t;
        rf_we     = 1'b0;
        rf_wa     = f_r;
        rf_wd     = sum;
        unique case (state)
            ST_FETCH_HI: mem_addr = pc;
            ST_FETCH_LO: mem_addr = pc + AW'(1);
            ST_DECODE:   mem_addr = pc;
            ST_EXEC: begin
                mem_addr = f_xy;
                mem_we   = (f_op == OPC_STORE);
                rf_we    = (f_op == OPC_ADD);
            end
            ST_WRITEBACK: begin
                mem_addr = f_xy;
                rf_we    = 1'b1;
                rf_wd    = mem_rdata;
            end
            ST_HALT:     mem_addr = pc;
            default:     mem_addr = pc;
        endcase
    end

    assign halted  = (state == ST_HALT);
    assign state_o = state;
endmodule

// File: rtl/simple_cpu.sv
module simple_cpu
    import cpu_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter int            RAW      = 4,
    parameter logic [AW-1:0] RESET_PC = 8'hA0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [AW-1:0]  load_addr,
    input  logic [DW-1:0]  load_data,
    input  logic [RAW-1:0] dbg_sel,
    output logic [DW-1:0]  dbg_data,
    output logic           halted,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           mem_we,
    output logic [DW-1:0]  mem_rdata
);
    logic [RAW-1:0] rf_ra_a, rf_ra_b, rf_wa;
    logic [DW-1:0]  rf_rd_a, rf_rd_b, rf_wd;
    logic           rf_we;
    cpu_state_e     ctrl_state;

    cpu_control #(
        .AW(AW), .DW(DW), .RAW(RAW), .RESET_PC(RESET_PC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .rf_ra_a   (rf_ra_a),
        .rf_ra_b   (rf_ra_b),
        .rf_rd_a   (rf_rd_a),
        .rf_rd_b   (rf_rd_b),
        .rf_we     (rf_we),
        .rf_wa     (rf_wa),
        .rf_wd     (rf_wd),
        .halted    (halted),
        .state_o   (ctrl_state)
    );

    cpu_regfile #(.DW(DW), .RAW(RAW)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a   (rf_ra_a),
        .ra_b   (rf_ra_b),
        .ra_dbg (dbg_sel),
        .rd_a   (rf_rd_a),
        .rd_b   (rf_rd_b),
        .rd_dbg (dbg_data),
        .we     (rf_we),
        .wa     (rf_wa),
        .wd     (rf_wd)
    );

    cpu_memory #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .ld_en   (load_en),
        .ld_addr (load_addr),
        .ld_data (load_data),
        .addr    (mem_addr),
        .we      (mem_we),
        .wdata   (mem_wdata),
        .rdata   (mem_rdata)
    );
endmodule

// File: rtl/simple_cpu_chk.sv
module simple_cpu_chk
    import cpu_pkg::*;
#(
    parameter int            AW       = 8,
    parameter logic [AW-1:0] RESET_PC = 8'hA0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halted,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input cpu_state_e    state
);
    p_first_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem_addr == RESET_PC));

    p_fetch_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_LO) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    p_store_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    p_halt_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr));

    p_halt_from_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> ($past(state) == ST_EXEC));
endmodule

bind simple_cpu simple_cpu_chk #(.AW(AW), .RESET_PC(RESET_PC)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halted   (halted),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .state    (ctrl_state)
);

// File: tb/test_simple_cpu.sv
module test_simple_cpu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [7:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [3:0] dbg_sel = '0;
    logic [7:0] dbg_data, mem_addr, mem_wdata, mem_rdata;
    logic       halted, mem_we;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct { logic [7:0] a; logic [7:0] d; string req; } item_t;
    item_t store_q[$];
    item_t reg_q[$];

    always #5 clk = ~clk;

    simple_cpu i_simple_cpu (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
        .halted(halted), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        load_en = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic expect_store(input logic [7:0] a, input logic [7:0] d, input string req);
        item_t it;
        it.a = a; it.d = d; it.req = req;
        store_q.push_back(it);
    endtask

    task automatic expect_reg(input logic [7:0] r, input logic [7:0] d, input string req);
        item_t it;
        it.a = r; it.d = d; it.req = req;
        reg_q.push_back(it);
    endtask

    // store monitor: pops one expected item per bus write
    always @(negedge clk) begin
        if (rst_n === 1'b1 && mem_we === 1'b1) begin
            if (store_q.size() == 0) begin
                chk("R7/R8 unexpected store addr", {8'h00, mem_addr}, 16'hFFFF);
            end else begin
                item_t it;
                it = store_q.pop_front();
                chk({it.req, " store addr"}, {8'h00, mem_addr}, {8'h00, it.a});
                chk({it.req, " store data"}, {8'h00, mem_wdata}, {8'h00, it.d});
            end
        end
    end

    task automatic drain_regs();
        while (reg_q.size() > 0) begin
            item_t it;
            it = reg_q.pop_front();
            @(negedge clk);
            dbg_sel = it.a[3:0];
            #1;
            chk(it.req, {8'h00, dbg_data}, {8'h00, it.d});
        end
    endtask

    task automatic clear_mem();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) put(8'(i), 8'h00);
    endtask

    task automatic run_to_halt(input string req);
        int n;
        n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (halted !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " halted (watchdog)"}, {15'd0, halted}, 16'h0001);
    endtask

    initial begin
        // ---------- program A ----------
        clear_mem();
        // R1: reset values
        for (int r = 0; r < 16; r++) begin
            dbg_sel = 4'(r); #1;
            chk("R1 reg reset", {8'h00, dbg_data}, 16'h0000);
        end
        chk("R1 halted low in reset", {15'd0, halted}, 16'h0000);
        put(8'h6C, 8'h9C);   // R10 preload
        put(8'h6D, 8'h35);
        put(8'hA0, 8'h15); put(8'hA1, 8'h6C);   // r5 = [6C]
        put(8'hA2, 8'h16); put(8'hA3, 8'h6D);   // r6 = [6D]
        put(8'hA4, 8'h50); put(8'hA5, 8'h56);   // r0 = r5 + r6
        put(8'hA6, 8'h30); put(8'hA7, 8'h6E);   // [6E] = r0
        put(8'hA8, 8'hF1); put(8'hA9, 8'h23);   // undefined
        put(8'hAA, 8'h57); put(8'hAB, 8'h55);   // r7 = r5 + r5 (carry out)
        put(8'hAC, 8'h2A); put(8'hAD, 8'hBC);   // undefined
        put(8'hAE, 8'h55); put(8'hAF, 8'h56);   // r5 = r5 + r6 (dest = src)
        put(8'hB0, 8'h35); put(8'hB1, 8'h70);   // [70] = r5
        put(8'hB2, 8'h18); put(8'hB3, 8'h70);   // r8 = [70]
        put(8'hB4, 8'hC0); put(8'hB5, 8'h00);   // halt
        put(8'hB6, 8'h39); put(8'hB7, 8'h71);   // must never run
        expect_store(8'h6E, 8'hD1, "R4/R5");
        expect_store(8'h70, 8'hD1, "R4/R6");

        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 first fetch address", {8'h00, mem_addr}, 16'h00A0);
        chk("R1 halted low after reset", {15'd0, halted}, 16'h0000);
        @(negedge clk); #1;
        chk("R2 second fetch address", {8'h00, mem_addr}, 16'h00A1);
        rst_n = 1'b0;   // restart program from the top
        run_to_halt("R7");

        begin
            logic [7:0] frozen;
            frozen = mem_addr;
            repeat (12) @(negedge clk);
            chk("R7 halted sticky", {15'd0, halted}, 16'h0001);
            chk("R7 address frozen", {8'h00, mem_addr}, {8'h00, frozen});
        end
        chk("R4 all stores seen", 16'(store_q.size()), 16'h0000);

        expect_reg(8'h5, 8'hD1, "R6 dest equals source");
        expect_reg(8'h6, 8'h35, "R10 preloaded byte loaded");
        expect_reg(8'h0, 8'hD1, "R5 add result");
        expect_reg(8'h7, 8'h38, "R5 add wraps");
        expect_reg(8'h8, 8'hD1, "R11 load after store");
        expect_reg(8'h9, 8'h00, "R8/R7 no stray writes");
        expect_reg(8'hA, 8'h00, "R8 undefined opcode no write");
        expect_reg(8'hB, 8'h00, "R8 undefined opcode no write");
        drain_regs();

        // ---------- program B: counter wrap ----------
        clear_mem();
        put(8'h80, 8'h5E);
        put(8'hA0, 8'h1A); put(8'hA1, 8'h80);   // rA = [80]
        put(8'hFE, 8'h3A); put(8'hFF, 8'h40);   // [40] = rA
        put(8'h00, 8'h3A); put(8'h01, 8'h41);   // [41] = rA after wrap
        put(8'h02, 8'hC0); put(8'h03, 8'h00);   // halt
        expect_store(8'h40, 8'h5E, "R9 store at FE");
        expect_store(8'h41, 8'h5E, "R9 store after wrap");
        run_to_halt("R9");
        repeat (4) @(negedge clk);
        chk("R9 all stores seen", 16'(store_q.size()), 16'h0000);
        chk("R3 halt address after wrap", {8'h00, mem_addr}, 16'h0004);
        expect_reg(8'hA, 8'h5E, "R3 load into register A");
        drain_regs();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule